// File: doc/BRIEF.md
# Posted Write Forwarding Sequencer

This block decides when posted memory-write data, held in a bridge's write buffer, is sent out on the destination bus. It also decides how each destination-side transaction ends. A write is loaded with its start address and total byte count. The sequencer then tracks, per cycle, how many bytes enter the buffer and how many bytes the bus layer delivers. From these it keeps the current address, the bytes still owed and the buffer level, all at byte granularity.

A burst is launched when the buffer holds the whole rest of the write, or when it holds enough data to reach the next 128-byte address boundary. At every boundary the burst carries on only if a full 128-byte block is buffered or the rest of the write is buffered. A transaction ends in one of six ways: normal completion, target abort (remaining data is dropped), target disconnect or retry, latency timer expiry with the grant removed, buffer running dry, or a boundary stop. In the cycle after each transaction the block reports the end cause and the bytes delivered. After a partial end it resumes from the advanced address with the reduced byte count. There is always at least one idle cycle between transactions.

Top module: `pwf_seq`

## Requirements
- R1: While reset is held and right after it, `req`, `pending`, `burst_start` and `end_valid` are 0.
- R2: A load (`ld_valid`) is accepted only when `pending` is 0, `req` is 0 and `ld_bcnt` is nonzero, and it sets `pending` in the next cycle. A load that breaks these conditions is ignored. `fill_bytes` is ignored while `pending` is 0.
- R3: `burst_start` is asserted, outside `req` and `end_valid`, in a cycle where bytes are pending, the buffer level L is nonzero and either L equals the remaining count or L is at least 128 minus the low 7 address bits. `req` is high from the next cycle. `dlv_bytes` counts only while `req` is high, and the bus layer never delivers across a 128-byte boundary in one cycle.
- R4: When a delivery brings the address to a multiple of 128 with bytes still owed, the burst continues if the level is at least 128 or equals the remaining count. Otherwise it ends with code 5.
- R5: If the level reaches 0 while bytes are still owed, the transaction ends with code 4.
- R6: A target disconnect or retry ends the transaction with code 2 and the write stays pending.
- R7: A target abort ends the transaction with code 1, drops all undelivered data and clears `pending`. Later fill data starts no burst.
- R8: `lat_expired` high with `gnt` low during a burst ends it with code 3.
- R9: When every byte has been delivered, the transaction ends with code 0 and `pending` clears.
- R10: End causes rank abort, then completion, then disconnect/retry, then latency, then empty, then boundary.
- R11: In the cycle after `req` was last high, `end_valid` is high for exactly one cycle with `req` low. `bcnt_dec` then equals the bytes delivered in that transaction, and no burst may start in that cycle.
- R12: While a burst starts, `start_addr` and `start_bcnt` show the current address and remaining count. After a partial end they equal the previous start values advanced by `bcnt_dec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load a new posted write |
| ld_addr | input | AW | Start byte address of the write |
| ld_bcnt | input | CW | Total byte count of the write |
| fill_bytes | input | DW | Bytes written into the buffer this cycle |
| dlv_bytes | input | DW | Bytes accepted by the target this cycle |
| tgt_disc | input | 1 | Target disconnect |
| tgt_retry | input | 1 | Target retry |
| tgt_abort | input | 1 | Target abort |
| lat_expired | input | 1 | Master latency timer expired |
| gnt | input | 1 | Destination bus grant |
| pending | output | 1 | A write has bytes left to deliver |
| burst_start | output | 1 | Launch a transaction this cycle |
| start_addr | output | AW | Address of the transaction being launched |
| start_bcnt | output | CW | Byte count of the transaction being launched |
| req | output | 1 | Transaction in progress |
| end_valid | output | 1 | Transaction-end report valid |
| end_code | output | 3 | End cause (0 done, 1 abort, 2 disconnect/retry, 3 latency, 4 empty, 5 boundary) |
| bcnt_dec | output | CW | Bytes delivered in the ended transaction |

## Verification
Random writes use arbitrary start offsets, trickling fill rates and stalled deliveries, so bursts start both on a buffered block boundary and on a buffered tail. This separates the two start rules. Directed runs place the address a few bytes before a boundary to pull boundary stop, boundary continuation and buffer-empty apart, since they differ only in the level left at the boundary. Terminations raised together with a final delivery, or with each other, confirm the ranking of end causes. The resume checks compare each restart address against the previous start plus the reported decrement.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2
  } pwf_st_e;

  typedef enum logic [2:0] {
    END_DONE  = 3'd0,
    END_ABORT = 3'd1,
    END_DISC  = 3'd2,
    END_LAT   = 3'd3,
    END_EMPTY = 3'd4,
    END_BOUND = 3'd5
  } pwf_end_e;
endpackage

// File: rtl/pwf_track.sv
// Byte-granular write progress: current address, bytes owed, buffer level,
// and bytes delivered in the open transaction.
module pwf_track #(
  parameter int AW = 32,
  parameter int CW = 12,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_acc,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_bcnt,
  input  logic [DW-1:0] fill_bytes,
  input  logic          dlv_en,
  input  logic [DW-1:0] dlv_bytes,
  input  logic          txn_clr,
  input  logic          flush,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] rem_q,
  output logic [CW-1:0] lvl_q,
  output logic [CW-1:0] txn_q,
  output logic [AW-1:0] addr_n,
  output logic [CW-1:0] rem_n,
  output logic [CW-1:0] lvl_n
);
  logic [CW-1:0] fill_e, dlv_e;
  logic [AW-1:0] addr_d;
  logic [CW-1:0] rem_d, lvl_d, txn_d;
  logic          upd_en;

  always_comb begin
    fill_e = (rem_q != '0) ? CW'(fill_bytes) : '0;
    dlv_e  = dlv_en ? CW'(dlv_bytes) : '0;
    addr_n = addr_q + AW'(dlv_e);
    rem_n  = rem_q - dlv_e;
    lvl_n  = lvl_q + fill_e - dlv_e;
    txn_d  = txn_clr ? '0 : (txn_q + dlv_e);
    if (ld_acc) begin
      addr_d = ld_addr;
      rem_d  = ld_bcnt;
      lvl_d  = '0;
    end else if (flush) begin
      addr_d = addr_n;
      rem_d  = '0;
      lvl_d  = '0;
    end else begin
      addr_d = addr_n;
      rem_d  = rem_n;
      lvl_d  = lvl_n;
    end
    upd_en = ld_acc | flush | txn_clr | (dlv_e != '0) | (fill_e != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      lvl_q  <= '0;
      txn_q  <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      lvl_q  <= lvl_d;
      txn_q  <= txn_d;
    end
  end
endmodule

// File: rtl/pwf_ctrl.sv
// Transaction sequencing: start rule, ranked end causes, idle gap.
module pwf_ctrl
  import pwf_pkg::*;
#(
  parameter int CW  = 12,
  parameter int DW  = 4,
  parameter int BLK = 128,
  parameter int BW  = $clog2(BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [CW-1:0] ld_bcnt,
  input  logic [BW-1:0] off_q,
  input  logic [BW-1:0] off_n,
  input  logic [CW-1:0] rem_q,
  input  logic [CW-1:0] lvl_q,
  input  logic [CW-1:0] rem_n,
  input  logic [CW-1:0] lvl_n,
  input  logic [DW-1:0] dlv_bytes,
  input  logic          tgt_disc,
  input  logic          tgt_retry,
  input  logic          tgt_abort,
  input  logic          lat_expired,
  input  logic          gnt,
  output logic          ld_acc,
  output logic          burst_start,
  output logic          in_burst,
  output logic          in_gap,
  output logic          flush,
  output logic [2:0]    end_code
);
  localparam logic [CW-1:0] BLK_C = CW'(BLK);

  pwf_st_e       st_q, st_d;
  pwf_end_e      code_q, code_d;
  logic          stop;
  logic [BW:0]   to_bnd;
  logic          at_bnd, bnd_ok;

  always_comb begin
    to_bnd   = (BW+1)'(BLK) - {1'b0, off_q};
    in_burst = (st_q == ST_BURST);
    in_gap   = (st_q == ST_GAP);
    burst_start = (st_q == ST_IDLE) && (rem_q != '0) && (lvl_q != '0) &&
                  ((lvl_q == rem_q) || (lvl_q >= CW'(to_bnd)));
    ld_acc   = ld_valid && (rem_q == '0) && !in_burst && (ld_bcnt != '0);
    flush    = in_burst && tgt_abort;
    at_bnd   = (|dlv_bytes) && (off_n == '0) && (rem_n != '0);
    bnd_ok   = (lvl_n >= BLK_C) || (lvl_n == rem_n);

    stop   = 1'b1;
    code_d = code_q;
    if (tgt_abort)                   code_d = END_ABORT;
    else if (rem_n == '0)            code_d = END_DONE;
    else if (tgt_disc || tgt_retry)  code_d = END_DISC;
    else if (lat_expired && !gnt)    code_d = END_LAT;
    else if (lvl_n == '0)            code_d = END_EMPTY;
    else if (at_bnd && !bnd_ok)      code_d = END_BOUND;
    else                             stop   = 1'b0;

    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (burst_start) st_d = ST_BURST;
      ST_BURST: if (stop)        st_d = ST_GAP;
      default:                   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              code_q <= END_DONE;
    else if (in_burst && stop) code_q <= code_d;
  end

  assign end_code = code_q;
endmodule

// File: rtl/pwf_seq.sv
module pwf_seq #(
  parameter int AW   = 32,
  parameter int CW   = 12,
  parameter int BEAT = 8,
  parameter int BLK  = 128,
  parameter int DW   = $clog2(BEAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_bcnt,
  input  logic [DW-1:0] fill_bytes,
  input  logic [DW-1:0] dlv_bytes,
  input  logic          tgt_disc,
  input  logic          tgt_retry,
  input  logic          tgt_abort,
  input  logic          lat_expired,
  input  logic          gnt,
  output logic          pending,
  output logic          burst_start,
  output logic [AW-1:0] start_addr,
  output logic [CW-1:0] start_bcnt,
  output logic          req,
  output logic          end_valid,
  output logic [2:0]    end_code,
  output logic [CW-1:0] bcnt_dec
);
  localparam int BW = $clog2(BLK);

  logic          ld_acc, in_burst, in_gap, flush;
  logic [AW-1:0] addr_q, addr_n;
  logic [CW-1:0] rem_q, lvl_q, txn_q, rem_n, lvl_n;

  pwf_track #(.AW(AW), .CW(CW), .DW(DW)) u_track (
    .clk(clk), .rst_n(rst_n), .ld_acc(ld_acc), .ld_addr(ld_addr), .ld_bcnt(ld_bcnt),
    .fill_bytes(fill_bytes), .dlv_en(in_burst), .dlv_bytes(dlv_bytes),
    .txn_clr(burst_start), .flush(flush), .addr_q(addr_q), .rem_q(rem_q),
    .lvl_q(lvl_q), .txn_q(txn_q), .addr_n(addr_n), .rem_n(rem_n), .lvl_n(lvl_n)
  );

  pwf_ctrl #(.CW(CW), .DW(DW), .BLK(BLK), .BW(BW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_bcnt(ld_bcnt),
    .off_q(addr_q[BW-1:0]), .off_n(addr_n[BW-1:0]), .rem_q(rem_q), .lvl_q(lvl_q),
    .rem_n(rem_n), .lvl_n(lvl_n), .dlv_bytes(dlv_bytes), .tgt_disc(tgt_disc),
    .tgt_retry(tgt_retry), .tgt_abort(tgt_abort), .lat_expired(lat_expired), .gnt(gnt),
    .ld_acc(ld_acc), .burst_start(burst_start), .in_burst(in_burst), .in_gap(in_gap),
    .flush(flush), .end_code(end_code)
  );

  assign pending    = (rem_q != '0);
  assign start_addr = addr_q;
  assign start_bcnt = rem_q;
  assign req        = in_burst;
  assign end_valid  = in_gap;
  assign bcnt_dec   = txn_q;
endmodule

// File: rtl/pwf_seq_chk.sv
module pwf_seq_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pending,
  input logic          burst_start,
  input logic          req,
  input logic          end_valid,
  input logic [2:0]    end_code,
  input logic [CW-1:0] bcnt_dec
);
  AST_START_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> pending); // R3
  AST_START_THEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> req); // R3
  AST_NO_START_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !burst_start); // R3
  AST_END_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> end_valid); // R11
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_valid |=> (!end_valid && !req)); // R11
  AST_END_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    end_valid |-> !burst_start); // R11
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_code == 3'd0) |-> (!pending && bcnt_dec != '0)); // R9
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_code == 3'd1) |-> !pending); // R7
  AST_PARTIAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (end_valid && end_code >= 3'd2) |-> pending); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    end_valid |-> (end_code <= 3'd5)); // R10
endmodule

bind pwf_seq pwf_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pending(pending), .burst_start(burst_start),
  .req(req), .end_valid(end_valid), .end_code(end_code), .bcnt_dec(bcnt_dec)
);

// File: tb/pwf_seq_test.sv
module pwf_seq_test;
  localparam int AW = 32, CW = 12, BEAT = 8, DW = 4;

  logic clk, rst_n;
  logic ld_valid, tgt_disc, tgt_retry, tgt_abort, lat_expired, gnt;
  logic [AW-1:0] ld_addr, start_addr;
  logic [CW-1:0] ld_bcnt, start_bcnt, bcnt_dec;
  logic [DW-1:0] fill_bytes, dlv_bytes;
  logic pending, burst_start, req, end_valid;
  logic [2:0] end_code;

  pwf_seq #(.AW(AW), .CW(CW), .BEAT(BEAT)) uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  int m_st = 0, m_rem = 0, m_lvl = 0, m_txn = 0, m_code = 0, unfilled = 0;
  logic [31:0] m_addr = 0;
  logic [31:0] last_sa = 0;
  int last_sb = 0, last_dec = 0;
  bit last_partial = 0;

  function automatic string code_tag(int c);
    case (c)
      0: return "R9";  1: return "R7";  2: return "R6";
      3: return "R8";  4: return "R5";  default: return "R4";
    endcase
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic bit exp_start();
    return (m_st == 0) && (m_rem != 0) && (m_lvl != 0) &&
           ((m_lvl == m_rem) || (m_lvl >= 128 - int'(m_addr[6:0])));
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check, then update the model at posedge
  task automatic step(bit ld, logic [31:0] la, int lb, int fill, int dlv,
                      bit dsc, bit rty, bit abt, bit lat, bit g);
    bit st, ld_acc;
    int fe, de, n_rem, n_lvl, code;
    logic [31:0] n_addr;
    ld_valid = ld; ld_addr = la; ld_bcnt = CW'(lb);
    fill_bytes = DW'(fill); dlv_bytes = DW'(dlv);
    tgt_disc = dsc; tgt_retry = rty; tgt_abort = abt; lat_expired = lat; gnt = g;
    #2;
    st = exp_start();
    chk("R3", "req", req, m_st == 1);
    chk("R11", "end_valid", end_valid, m_st == 2);
    chk("R2", "pending", pending, m_rem != 0);
    chk("R3", "burst_start", burst_start, st);
    if (st) begin
      chk("R12", "start_addr", start_addr, m_addr);
      chk("R12", "start_bcnt", start_bcnt, m_rem);
      if (last_partial) begin
        chk("R12", "resume_addr", start_addr, last_sa + last_dec);
        chk("R12", "resume_bcnt", start_bcnt, last_sb - last_dec);
      end
      last_partial = 0;
      last_sa = m_addr; last_sb = m_rem;
    end
    if (m_st == 2) begin
      chk(code_tag(m_code), "end_code", end_code, m_code);
      chk("R11", "bcnt_dec", bcnt_dec, m_txn);
    end
    @(posedge clk);
    fe = (m_rem != 0) ? fill : 0;
    de = (m_st == 1) ? dlv : 0;
    ld_acc = ld && (m_rem == 0) && (m_st != 1) && (lb != 0);
    n_addr = m_addr + de; n_rem = m_rem - de; n_lvl = m_lvl + fe - de;
    code = -1;
    if (m_st == 1) begin
      if (abt) code = 1;
      else if (n_rem == 0) code = 0;
      else if (dsc || rty) code = 2;
      else if (lat && !g) code = 3;
      else if (n_lvl == 0) code = 4;
      else if (de != 0 && n_addr[6:0] == 0 && !(n_lvl >= 128 || n_lvl == n_rem)) code = 5;
    end
    m_txn = st ? 0 : m_txn + de;
    unfilled -= fe;
    if (m_st == 1 && abt) begin n_rem = 0; n_lvl = 0; unfilled = 0; end
    if (ld_acc) begin n_addr = la; n_rem = lb; n_lvl = 0; unfilled = lb; end
    m_addr = n_addr; m_rem = n_rem; m_lvl = n_lvl;
    case (m_st)
      0: if (st) m_st = 1;
      1: if (code >= 0) begin
           m_st = 2; m_code = code;
           if (code >= 2) begin last_partial = 1; last_dec = m_txn; end
         end
      default: m_st = 0;
    endcase
    @(negedge clk);
  endtask

  // legal stimulus: fill bounded by data still to come, delivery by level,
  // remaining count and the next 128-byte boundary
  task automatic drive(int fw, int dw, bit dsc, bit rty, bit abt, bit lat, bit g);
    int f, d;
    f = (m_rem != 0) ? imin(fw, unfilled) : fw;
    d = (m_st == 1) ? imin(imin(dw, m_lvl), imin(m_rem, 128 - int'(m_addr[6:0]))) : 0;
    step(0, 0, 0, f, d, dsc, rty, abt, lat, g);
  endtask

  task automatic run_to_end(int fw, int dw);
    for (int i = 0; i < 200 && m_st != 2; i++) drive(fw, dw, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20051));
    rst_n = 0; ld_valid = 0; ld_addr = 0; ld_bcnt = 0; fill_bytes = 0; dlv_bytes = 0;
    tgt_disc = 0; tgt_retry = 0; tgt_abort = 0; lat_expired = 0; gnt = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset req", req, 0);
    chk("R1", "reset pending", pending, 0);
    chk("R1", "reset burst_start", burst_start, 0);
    chk("R1", "reset end_valid", end_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: zero-count load ignored, fill while idle ignored
    step(1, 32'h40, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 8, 0, 0, 0, 0, 0, 1);
    #2 chk("R2", "zero load ignored", pending, 0);
    @(negedge clk);

    // R4 boundary stop: 16 bytes short of a block edge, 40 buffered
    step(1, 32'h1000_0070, 300, 0, 0, 0, 0, 0, 0, 1);
    step(1, 32'h2000_0000, 77, 0, 0, 0, 0, 0, 0, 1); // R2 load ignored while pending
    chk("R2", "busy load ignored", start_addr, 32'h1000_0070);
    for (int i = 0; i < 5; i++) drive(8, 0, 0, 0, 0, 0, 1);
    run_to_end(0, 8);
    chk("R4", "boundary stop code", end_code, 5);
    chk("R11", "boundary dec", bcnt_dec, 16);
    // R4 continue: full block buffered at the edge keeps the burst going
    for (int i = 0; i < 13; i++) drive(8, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 17; i++) drive(8, 8, 0, 0, 0, 0, 1);
    chk("R4", "continues past edge", req, 1);
    drive(0, 8, 1, 0, 0, 0, 1);           // R6 disconnect
    chk("R6", "disconnect code", end_code, 2);
    chk("R6", "still pending", pending, 1);
    for (int i = 0; i < 20 && m_st != 1; i++) drive(8, 0, 0, 0, 0, 0, 1);
    drive(0, 8, 0, 0, 0, 1, 0);           // R8 latency with grant gone
    chk("R8", "latency code", end_code, 3);
    for (int i = 0; i < 20 && m_st != 1; i++) drive(8, 0, 0, 0, 0, 0, 1);
    drive(0, 8, 0, 1, 1, 1, 0);           // R10 abort outranks retry and latency
    chk("R10", "abort wins", end_code, 1);
    chk("R7", "abort clears pending", pending, 0);
    for (int i = 0; i < 4; i++) drive(8, 0, 0, 0, 0, 0, 1);
    chk("R7", "no burst after abort", req, 0);

    // R5 empty: 4 bytes before an edge, only 4 buffered
    step(1, 32'h0000_007C, 50, 0, 0, 0, 0, 0, 0, 1);
    drive(4, 0, 0, 0, 0, 0, 1);
    run_to_end(0, 8);
    chk("R5", "empty code", end_code, 4);
    // R9/R10: tail fully buffered, disconnect on the final delivery
    for (int i = 0; i < 30 && m_st != 1; i++) drive(8, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 20 && m_st == 1; i++) drive(0, 8, m_rem <= 8, 0, 0, 0, 1);
    chk("R10", "done outranks disconnect", end_code, 0);
    chk("R9", "done clears pending", pending, 0);
    drive(0, 0, 0, 0, 0, 0, 1);

    // constrained random
    for (int n = 0; n < 30000; n++) begin
      if (m_rem == 0 && m_st != 1 && ($urandom % 4) == 0)
        step(1, $urandom, 1 + ($urandom % 700), 0, 0, 0, 0, 0, 0, 1);
      else
        drive(($urandom % 3 == 0) ? 0 : $urandom % 9, $urandom % 9,
              ($urandom % 40) == 0, ($urandom % 60) == 0, ($urandom % 150) == 0,
              ($urandom % 25) == 0, ($urandom % 4) != 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule